// File: doc/BRIEF.md
# Solid Rectangle Fill Engine

This block takes a rectangle-fill command as a stream of six 32-bit words on a valid/ready input. It writes one constant value into every pixel of a rectangle in a linear framebuffer. The first word is a header that carries the channel-enable flags. The second is a control word with the destination pitch in bytes, an eight-bit raster code and a two-bit pixel-depth code. Words three and four are the two corners. Word five is the destination base byte address and word six is the fill value.

When the command is complete, the engine visits the pixels in row-major order, one per clock cycle. For each pixel it drives a synchronous write port with a byte address, a 32-bit data word and per-byte enables. At 32 bits per pixel, two header flags let the colour bytes and the top byte be written separately, so a packed depth/stencil word can be cleared in part. An upper-level command processor feeds the input and a memory controller takes the writes.

Top module: `fill_blitter`

## Requirements
- R1: Words are taken on cycles where `cmd_valid` and `cmd_ready` are both high. The order is header, control, top-left corner, bottom-right corner, base address, fill value. `cmd_ready` is low on every cycle in which a write is issued, so no word is accepted while the rectangle is being written.
- R2: Each corner word holds Y in bits 31:16 and X in bits 15:0. The bottom-right corner is exclusive. A rectangle produces (x2−x1)·(y2−y1) writes in row-major order, with X advancing fastest, starting in the cycle after the sixth word is accepted and continuing one per cycle.
- R3: The byte address of pixel (x, y) is base + y·pitch + x·B, where B is 2 at 16 bpp and 4 at 32 bpp.
- R4: In the control word, bits 15:0 hold the pitch in bytes, bits 23:16 hold the raster code and bits 25:24 hold the depth code: 01 selects 16 bpp and 11 selects 32 bpp. Depth codes 00 and 10 produce no writes.
- R5: At 16 bpp, each write carries the low 16 bits of the pixel value in data bits 15:0, zeros above, and byte enables 0011. The header flags have no effect.
- R6: At 32 bpp, header bit 20 enables byte lanes 2:0 and header bit 21 enables byte lane 3. The data is the full pixel value. With neither flag set, no writes occur.
- R7: A command with x1 ≥ x2 or y1 ≥ y2 produces no writes.
- R8: The pixel value is the fill value for raster code F0, its bitwise inverse for 0F, all zeros for 00 and all ones for FF. Any other code falls back to the fill value.
- R9: `busy` is high from the cycle after the first word is accepted through the cycle of the last write. `done` is high for exactly one cycle: the cycle after the last write, or the cycle after the sixth word when the command produces no writes.
- R10: Out of reset, `cmd_ready` is high and `busy`, `done` and `wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command word present |
| cmd_data | input | 32 | Command word |
| cmd_ready | output | 1 | Engine can take a command word |
| busy | output | 1 | Command collection or rectangle walk in progress |
| done | output | 1 | One-cycle completion pulse |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | ADDR_W | Byte address of the pixel |
| wr_data | output | 32 | Pixel data |
| wr_be | output | 4 | Byte-lane enables |

## Verification
On every cycle, the assertions check the following:
- a write is issued only while `busy` is high and `cmd_ready` is low;
- every write has a non-empty, legal byte-enable pattern;
- back-to-back writes move to a new address;
- `done` never lasts two cycles and never coincides with a write.

Only the bench scenarios can show the rest: the exact address sequence for a given corner pair and pitch, the pixel value for each raster code, the lane pattern for each flag combination, and the absence of writes for empty rectangles, disabled channels and unsupported depth codes.

// File: rtl/fill_pkg.sv
package fill_pkg;

   localparam int WORD_W  = 32;
   localparam int BE_W    = WORD_W / 8;
   localparam int COORD_W = 16;

   typedef enum logic [1:0] {
      DEPTH_NONE = 2'd0,
      DEPTH_16   = 2'd1,
      DEPTH_32   = 2'd2
   } depth_e;

   typedef struct packed {
      logic [COORD_W-1:0] x1;
      logic [COORD_W-1:0] y1;
      logic [COORD_W-1:0] x2;
      logic [COORD_W-1:0] y2;
      logic [COORD_W-1:0] pitch;
      logic [7:0]         rop;
      depth_e             depth;
      logic               rgb_en;
      logic               alpha_en;
      logic [WORD_W-1:0]  base;
      logic [WORD_W-1:0]  color;
   } fill_cmd_t;

endpackage

// File: rtl/fill_cmd_rx.sv
module fill_cmd_rx
   import fill_pkg::*;
#(
   parameter int RGB_BIT   = 20,
   parameter int ALPHA_BIT = 21
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_data,
   input  logic              accept_en,
   output logic              fire,
   output logic              collecting,
   output fill_cmd_t         cmd
);

   localparam int NWORDS = 6;
   localparam int NHELD  = NWORDS - 1;
   localparam int IDX_W  = $clog2(NWORDS);

   logic [IDX_W-1:0]  idx;
   logic [WORD_W-1:0] held [NHELD];
   logic              hs;

   assign hs         = in_valid & accept_en;
   assign fire       = hs && (idx == IDX_W'(NWORDS - 1));
   assign collecting = (idx != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx <= '0;
      end else if (hs) begin
         idx <= fire ? '0 : idx + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < NHELD; i++) begin
         if (hs && (idx == IDX_W'(i))) held[i] <= in_data;
      end
   end

   // word 0 header, 1 control, 2 top-left, 3 bottom-right, 4 base, 5 value
   always_comb begin
      cmd.alpha_en = held[0][ALPHA_BIT];
      cmd.rgb_en   = held[0][RGB_BIT];
      cmd.pitch    = held[1][15:0];
      cmd.rop      = held[1][23:16];
      unique case (held[1][25:24])
         2'b01:   cmd.depth = DEPTH_16;
         2'b11:   cmd.depth = DEPTH_32;
         default: cmd.depth = DEPTH_NONE;
      endcase
      cmd.x1    = held[2][15:0];
      cmd.y1    = held[2][31:16];
      cmd.x2    = held[3][15:0];
      cmd.y2    = held[3][31:16];
      cmd.base  = held[4];
      cmd.color = in_data;
   end

   logic unused_bits;
   assign unused_bits = ^{held[0], held[1][31:26]};

endmodule

// File: rtl/fill_walk.sv
module fill_walk
   import fill_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter bit ROP_FULL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  fill_cmd_t         cmd,
   output logic              active,
   output logic              done,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [WORD_W-1:0] wr_data,
   output logic [BE_W-1:0]   wr_be
);

   logic [COORD_W-1:0] width, height;
   logic [2:0]         step;
   logic [BE_W-1:0]    be_n;
   logic [WORD_W-1:0]  pix, data_n;
   logic               non_empty;
   logic [WORD_W-1:0]  row_off, col_off;
   logic [ADDR_W-1:0]  start_addr;

   if (ROP_FULL) begin : g_rop_full
      always_comb begin
         unique case (cmd.rop)
            8'h0F:   pix = ~cmd.color;
            8'h00:   pix = '0;
            8'hFF:   pix = '1;
            default: pix = cmd.color;
         endcase
      end
   end else begin : g_rop_solid
      assign pix = cmd.color;
   end

   always_comb begin
      unique case (cmd.depth)
         DEPTH_16: begin
            step   = 3'd2;
            be_n   = 4'b0011;
            data_n = {16'h0000, pix[15:0]};
         end
         DEPTH_32: begin
            step   = 3'd4;
            be_n   = {cmd.alpha_en, {3{cmd.rgb_en}}};
            data_n = pix;
         end
         default: begin
            step   = 3'd0;
            be_n   = '0;
            data_n = '0;
         end
      endcase
   end

   assign width      = cmd.x2 - cmd.x1;
   assign height     = cmd.y2 - cmd.y1;
   assign non_empty  = (cmd.x1 < cmd.x2) && (cmd.y1 < cmd.y2) && (be_n != '0);
   assign row_off    = 32'(cmd.y1) * 32'(cmd.pitch);
   assign col_off    = 32'(cmd.x1) * 32'(step);
   assign start_addr = ADDR_W'(cmd.base + row_off + col_off);

   logic [COORD_W-1:0] col_cnt, width_m1, row_cnt;
   logic [ADDR_W-1:0]  row_addr, addr, pitch_q;
   logic [2:0]         step_q;
   logic [BE_W-1:0]    be_q;
   logic [WORD_W-1:0]  data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active   <= 1'b0;
         done     <= 1'b0;
         col_cnt  <= '0;
         width_m1 <= '0;
         row_cnt  <= '0;
         row_addr <= '0;
         addr     <= '0;
         pitch_q  <= '0;
         step_q   <= '0;
         be_q     <= '0;
         data_q   <= '0;
      end else begin
         done <= 1'b0;
         if (load) begin
            active   <= non_empty;
            done     <= ~non_empty;
            col_cnt  <= width - 1'b1;
            width_m1 <= width - 1'b1;
            row_cnt  <= height - 1'b1;
            row_addr <= start_addr;
            addr     <= start_addr;
            pitch_q  <= ADDR_W'(cmd.pitch);
            step_q   <= step;
            be_q     <= be_n;
            data_q   <= data_n;
         end else if (active) begin
            if (col_cnt == '0) begin
               if (row_cnt == '0) begin
                  active <= 1'b0;
                  done   <= 1'b1;
               end else begin
                  row_cnt  <= row_cnt - 1'b1;
                  col_cnt  <= width_m1;
                  row_addr <= row_addr + pitch_q;
                  addr     <= row_addr + pitch_q;
               end
            end else begin
               col_cnt <= col_cnt - 1'b1;
               addr    <= addr + ADDR_W'(step_q);
            end
         end
      end
   end

   assign wr_addr = addr;
   assign wr_data = data_q;
   assign wr_be   = be_q;

endmodule

// File: rtl/fill_blitter.sv
module fill_blitter
   import fill_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int RGB_BIT   = 20,
   parameter int ALPHA_BIT = 21,
   parameter bit ROP_FULL  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [WORD_W-1:0] cmd_data,
   output logic              cmd_ready,
   output logic              busy,
   output logic              done,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [WORD_W-1:0] wr_data,
   output logic [BE_W-1:0]   wr_be
);

   if (ADDR_W < COORD_W || ADDR_W > WORD_W) begin : g_bad_addr
      $error("fill_blitter: ADDR_W must lie between 16 and 32");
   end
   if (RGB_BIT == ALPHA_BIT || RGB_BIT < 0 || RGB_BIT >= WORD_W ||
       ALPHA_BIT < 0 || ALPHA_BIT >= WORD_W) begin : g_bad_flags
      $error("fill_blitter: channel flag bits must be distinct header bits");
   end

   fill_cmd_t cmd;
   logic      fire, collecting, active;

   assign cmd_ready = ~active;
   assign busy      = collecting | active;
   assign wr_en     = active;

   fill_cmd_rx #(
      .RGB_BIT   (RGB_BIT),
      .ALPHA_BIT (ALPHA_BIT)
   ) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (cmd_valid),
      .in_data    (cmd_data),
      .accept_en  (cmd_ready),
      .fire       (fire),
      .collecting (collecting),
      .cmd        (cmd)
   );

   fill_walk #(
      .ADDR_W   (ADDR_W),
      .ROP_FULL (ROP_FULL)
   ) u_walk (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (fire),
      .cmd     (cmd),
      .active  (active),
      .done    (done),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .wr_be   (wr_be)
   );

endmodule

// File: rtl/fill_blitter_chk.sv
module fill_blitter_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_ready,
   input logic              busy,
   input logic              done,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [3:0]        wr_be
);

   a_r9_write_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> busy);

   a_r1_no_accept_while_writing: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !cmd_ready);

   a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r9_done_after_writes: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !wr_en);

   a_r6_lanes_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_be != 4'b0000));

   a_r5_lane_pattern: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_be == 4'b0011 || wr_be[2:0] == 3'b111 || wr_be[2:0] == 3'b000));

   a_r3_address_advances: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && $past(wr_en)) |-> (wr_addr != $past(wr_addr)));

endmodule

bind fill_blitter fill_blitter_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_ready (cmd_ready),
   .busy      (busy),
   .done      (done),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .wr_be     (wr_be)
);

// File: tb/fill_blitter_tb.sv
module fill_blitter_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [31:0] cmd_data = '0;
   logic        cmd_ready, busy, done, wr_en;
   logic [31:0] wr_addr, wr_data;
   logic [3:0]  wr_be;

   always #5 clk = ~clk;

   fill_blitter u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_data  (cmd_data),
      .cmd_ready (cmd_ready),
      .busy      (busy),
      .done      (done),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .wr_be     (wr_be)
   );

   localparam logic [31:0] HD  = 32'h5000_0000;
   localparam logic [31:0] FR  = 32'h0010_0000;  // colour lanes flag, bit 20
   localparam logic [31:0] FA  = 32'h0020_0000;  // top lane flag, bit 21

   function automatic logic [31:0] cw(input logic [1:0] dep, input logic [7:0] rop,
                                      input logic [15:0] pitch);
      return {6'b0, dep, rop, pitch};
   endfunction

   localparam int NV = 14;
   // {header, control, top-left, bottom-right, base, value}
   localparam logic [191:0] VEC [NV] = '{
      {HD|FR|FA, cw(2'b11, 8'hF0, 16'd64), 32'h0001_0002, 32'h0003_0005, 32'h0000_1000, 32'hAABB_CCDD}, // R2 R3 R6
      {HD,       cw(2'b01, 8'hF0, 16'd32), 32'h0000_0000, 32'h0002_0004, 32'h0000_0200, 32'h1234_5678}, // R5
      {HD|FA,    cw(2'b01, 8'hF0, 16'd40), 32'h0003_0001, 32'h0004_0003, 32'h0000_0000, 32'h0000_BEEF}, // R5 flags ignored
      {HD|FR,    cw(2'b11, 8'hF0, 16'd100),32'h0000_0000, 32'h0002_0001, 32'h0000_4000, 32'h1122_3344}, // R6 colour only
      {HD|FA,    cw(2'b11, 8'hF0, 16'd16), 32'h0005_0000, 32'h0006_0003, 32'h0000_0000, 32'h5566_7788}, // R6 top only
      {HD,       cw(2'b11, 8'hF0, 16'd16), 32'h0000_0000, 32'h0002_0002, 32'h0000_0000, 32'h9999_9999}, // R6 no flags
      {HD|FR|FA, cw(2'b11, 8'h0F, 16'd8),  32'h0000_0000, 32'h0001_0002, 32'h0000_0100, 32'h0F0F_00FF}, // R8 inverse
      {HD|FR|FA, cw(2'b11, 8'h00, 16'd12), 32'h0002_0001, 32'h0003_0002, 32'h0000_0300, 32'hDEAD_BEEF}, // R8 zeros
      {HD,       cw(2'b01, 8'hFF, 16'd6),  32'h0001_0001, 32'h0003_0002, 32'h0000_0040, 32'h0000_0000}, // R8 ones
      {HD|FR|FA, cw(2'b11, 8'h66, 16'd20), 32'h0000_0003, 32'h0001_0005, 32'h0000_0800, 32'hCAFE_F00D}, // R8 other
      {HD|FR|FA, cw(2'b11, 8'hF0, 16'd64), 32'h0001_0004, 32'h0003_0004, 32'h0000_1000, 32'h0000_0001}, // R7 zero width
      {HD|FR|FA, cw(2'b11, 8'hF0, 16'd64), 32'h0005_0000, 32'h0002_0003, 32'h0000_1000, 32'h0000_0002}, // R7 inverted y
      {HD|FR|FA, cw(2'b00, 8'hF0, 16'd64), 32'h0000_0000, 32'h0002_0002, 32'h0000_1000, 32'h0000_0003}, // R4 code 00
      {HD|FR|FA, cw(2'b10, 8'hF0, 16'd64), 32'h0000_0000, 32'h0002_0002, 32'h0000_1000, 32'h0000_0004}  // R4 code 10
   };

   int total = 0;
   int bad   = 0;

   // write log filled by the monitor only
   logic [31:0] log_a [256];
   logic [31:0] log_d [256];
   logic [3:0]  log_b [256];
   int nw = 0;
   int ndone = 0;
   int nclash = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (wr_en) begin
            log_a[nw % 256] = wr_addr;
            log_d[nw % 256] = wr_data;
            log_b[nw % 256] = wr_be;
            nw = nw + 1;
            if (cmd_ready || !busy) nclash = nclash + 1;
         end
         if (done) ndone = ndone + 1;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic send_word(input logic [31:0] w);
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      cmd_valid = 1'b1;
      cmd_data  = w;
      @(negedge clk);
      cmd_valid = 1'b0;
      cmd_data  = '0;
   endtask

   task automatic run_vec(input int k, input string req);
      logic [191:0] v;
      logic [31:0] hdr, ctl, tl, br, base, col, pv, ed, ea;
      logic [3:0]  eb;
      int bpp, start, d0, c0, cnt, nexp, nmis;
      logic [31:0] fa, fe;
      v    = VEC[k];
      hdr  = v[191:160]; ctl = v[159:128]; tl = v[127:96];
      br   = v[95:64];   base = v[63:32];  col = v[31:0];
      start = nw; d0 = ndone; c0 = nclash;
      for (int i = 5; i >= 0; i--) send_word(v[i*32 +: 32]);
      cnt = 0;
      while (ndone == d0 && cnt < 3000) begin @(negedge clk); cnt++; end
      check(cnt < 3000, req, "completion timeout", 32'(cnt), 32'd0);
      @(negedge clk); @(negedge clk);
      // model of the expected write stream
      case (ctl[23:16])
         8'h0F:   pv = ~col;
         8'h00:   pv = 32'h0;
         8'hFF:   pv = 32'hFFFF_FFFF;
         default: pv = col;
      endcase
      bpp = (ctl[25:24] == 2'b01) ? 2 : (ctl[25:24] == 2'b11) ? 4 : 0;
      if (bpp == 2) begin eb = 4'b0011; ed = {16'h0, pv[15:0]}; end
      else          begin eb = {hdr[21], {3{hdr[20]}}}; ed = pv; end
      nexp = 0; nmis = 0; fa = 0; fe = 0;
      if (bpp != 0 && eb != 4'b0000) begin
         for (int y = int'(tl[31:16]); y < int'(br[31:16]); y++) begin
            for (int x = int'(tl[15:0]); x < int'(br[15:0]); x++) begin
               ea = base + 32'(y) * 32'(ctl[15:0]) + 32'(x * bpp);
               if (start + nexp < nw) begin
                  if (log_a[(start+nexp)%256] !== ea || log_d[(start+nexp)%256] !== ed ||
                      log_b[(start+nexp)%256] !== eb) begin
                     if (nmis == 0) begin fa = log_a[(start+nexp)%256]; fe = ea; end
                     nmis++;
                  end
               end
               nexp++;
            end
         end
      end
      check(nw - start == nexp, req, "write count", 32'(nw - start), 32'(nexp));
      check(nmis == 0, req, "write address/data/lanes", fa, fe);
      check(ndone - d0 == 1, "R9", "done pulses", 32'(ndone - d0), 32'd1);
      check(nclash == c0, "R1", "ready high or busy low during write",
            32'(nclash - c0), 32'd0);
   endtask

   initial begin : wd
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R10 reset state
      check(cmd_ready === 1'b1, "R10", "cmd_ready in reset", 32'(cmd_ready), 32'd1);
      check(busy === 1'b0 && done === 1'b0 && wr_en === 1'b0, "R10", "busy/done/wr_en in reset",
            {29'd0, busy, done, wr_en}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(cmd_ready === 1'b1 && busy === 1'b0, "R10", "idle after reset",
            {30'd0, cmd_ready, busy}, 32'd2);
      for (int k = 0; k < NV; k++) begin
         string req;
         case (k)
            0: req = "R2"; 1, 2: req = "R5"; 3, 4, 5: req = "R6";
            6, 7, 8, 9: req = "R8"; 10, 11: req = "R7"; default: req = "R4";
         endcase
         run_vec(k, req);
      end
      // R3 directed: odd pitch, second row start address
      begin
         int s;
         s = nw;
         send_word(HD|FR|FA); send_word(cw(2'b11, 8'hF0, 16'd37));
         send_word(32'h0002_0003); send_word(32'h0004_0004);
         send_word(32'h0001_0000); send_word(32'h7777_7777);
         repeat (6) @(negedge clk);
         check(nw - s == 2, "R3", "odd pitch count", 32'(nw - s), 32'd2);
         check(log_a[s%256] == 32'h0001_0000 + 32'd74 + 32'd12, "R3", "odd pitch row 2",
               log_a[s%256], 32'h0001_0000 + 32'd86);
         check(log_a[(s+1)%256] == 32'h0001_0000 + 32'd111 + 32'd12, "R3", "odd pitch row 3",
               log_a[(s+1)%256], 32'h0001_0000 + 32'd123);
      end
      // R9 busy after the first word, before the command completes
      @(negedge clk);
      cmd_valid = 1'b1; cmd_data = HD;
      @(negedge clk);
      cmd_valid = 1'b0;
      check(busy === 1'b1, "R9", "busy after first word", 32'(busy), 32'd1);
      for (int i = 0; i < 5; i++) send_word(i == 0 ? cw(2'b01, 8'hF0, 16'd4) :
                                            i == 2 ? 32'h0001_0001 : 32'h0);
      repeat (4) @(negedge clk);
      check(busy === 1'b0, "R9", "busy clear after completion", 32'(busy), 32'd0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule